// File: doc/BRIEF.md
# Self-Timed Fall-Through Word Stack

This block is the storage core of a first-in first-out buffer that works without read or write pointers. It is a column of fourteen four-bit word locations. Each location has its own occupancy bit. A word written at the top end falls toward the output end one location per clock. It stops only when the location below it is still holding an earlier word. The bottom location is the only place a word is offered to the output side. Words therefore leave in the order they came in.

The input side writes through a valid/ready pair. The top location accepts a word only while it is empty. The output side sees the bottom occupancy bit as its valid flag and removes the word by raising a take strobe. When the bottom word leaves, the words above it can move down in the same cycle, so a packed column shifts as one unit. Master reset clears every occupancy bit but does not touch the stored data bits. The old bottom word therefore stays visible on the read data port after reset while valid is low.

Top module: `ftstk_top`

## Requirements
- R1: While reset is high at a clock edge, all occupancy is cleared: after that edge rd_valid is 0 and wr_ready is 1.
- R2: wr_ready is 1 exactly when the top location is empty. A word is stored only at an edge where wr_valid and wr_ready are both 1. A refused write adds no word.
- R3: A single word written into an empty stack reaches the output after DEPTH-1 further clock edges (13 with the defaults). From that edge on, rd_valid is 1 and rd_data equals the word.
- R4: A word moves down at most one location per clock. It moves only when the location below is empty or is handing its own word down in the same cycle. Otherwise the word and its data stay in place.
- R5: A location can pass its word down and take a new word from above in the same cycle. A full column drained with take held high gives rd_valid=1 on DEPTH consecutive cycles.
- R6: rd_valid is the bottom occupancy bit. Without take, rd_valid and rd_data hold. With take while rd_valid is 1, the bottom word is removed at that edge. rd_valid stays 1 only if a word from above moves in at the same edge.
- R7: rd_take while rd_valid is 0 has no effect on rd_valid, wr_ready or rd_data.
- R8: Words come out in write order, with none lost and none duplicated, under any timing of writes and takes.
- R9: Reset clears only occupancy. rd_data keeps showing the last word that reached the bottom location until a new word arrives there.
- R10: The stack holds exactly DEPTH words (14 by default). After DEPTH writes with no take, wr_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high master reset (clears occupancy only) |
| wr_valid | input | 1 | Write request from the input register |
| wr_data | input | WIDTH | Word to write |
| wr_ready | output | 1 | Top location empty; write accepted when wr_valid is also high |
| rd_valid | output | 1 | Bottom location holds a word |
| rd_data | output | WIDTH | Contents of the bottom location |
| rd_take | input | 1 | Output side takes the bottom word |

## Verification
Some properties are checked by assertions on every cycle. The number of occupied locations changes by exactly the accepted writes minus the taken words. A held location never loses its word or changes its data. A word is never written into a location that is still full. A bottom word that is not taken stays valid and stable. A refused write adds nothing. Reset empties the column.

Other behaviour needs the bench's scenarios. These are the exact fall-through latency, capacity, the continuous drain of a packed column, and end-to-end word order under random write and take timing. They also include the data left visible after reset. The bench shows them by comparing the ports against a model that tracks each word's position on every clock.

// File: rtl/ftstk_pkg.sv
`timescale 1ns/1ps
package ftstk_pkg;

    localparam int unsigned FT_WIDTH = 4;
    localparam int unsigned FT_DEPTH = 14;

    // A location hands its word down when it is full and the location
    // below is either empty or itself handing down this cycle.
    function automatic logic can_give(logic occ, logic dn_occ, logic dn_give);
        return occ && (!dn_occ || dn_give);
    endfunction

    // Occupancy after the edge: kept unless handed down, set on fill.
    function automatic logic occ_next(logic occ, logic give, logic fill);
        return (occ && !give) || fill;
    endfunction

endpackage

// File: rtl/ftstk_flow.sv
`timescale 1ns/1ps
module ftstk_flow
    import ftstk_pkg::*;
#(
    parameter int unsigned DEPTH = FT_DEPTH
) (
    input  logic [DEPTH-1:0] occ,
    input  logic             wr_valid,
    input  logic             rd_take,
    output logic [DEPTH-1:0] give,
    output logic [DEPTH-1:0] fill,
    output logic             wr_ready
);

    localparam int unsigned LAST = DEPTH - 1;

    // Hand-down decisions ripple from the output end upward.
    always_comb begin
        give       = '0;
        give[LAST] = occ[LAST] && rd_take;
        for (int i = int'(LAST) - 1; i >= 0; i--) begin
            give[i] = can_give(occ[i], occ[i+1], give[i+1]);
        end
    end

    // The top takes a new word only when it is empty.
    assign wr_ready = !occ[0];

    always_comb begin
        fill    = '0;
        fill[0] = wr_valid && !occ[0];
        for (int i = 1; i < int'(DEPTH); i++) begin
            fill[i] = give[i-1];
        end
    end

endmodule

// File: rtl/ftstk_cell.sv
`timescale 1ns/1ps
module ftstk_cell
    import ftstk_pkg::*;
#(
    parameter int unsigned WIDTH = FT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill,
    input  logic             give,
    input  logic [WIDTH-1:0] up_data,
    output logic             occ,
    output logic [WIDTH-1:0] data
);

    // Occupancy is the only reset state.
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= 1'b0;
        end else begin
            occ <= occ_next(occ, give, fill);
        end
    end

    // Data is loaded on fill only and is never cleared.
    always_ff @(posedge clk) begin
        if (fill && !rst) begin
            data <= up_data;
        end
    end

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (occ && !give) |=> (occ && $stable(data)));  // R4

    AST_CELL_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        fill |-> (!occ || give));  // R8

endmodule

// File: rtl/ftstk_top.sv
`timescale 1ns/1ps
module ftstk_top
    import ftstk_pkg::*;
#(
    parameter int unsigned WIDTH = FT_WIDTH,
    parameter int unsigned DEPTH = FT_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_take
);

    localparam int unsigned LAST = DEPTH - 1;

    typedef logic [WIDTH-1:0] word_t;

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] give;
    logic [DEPTH-1:0] fill;
    word_t            loc_data [DEPTH];

    ftstk_flow #(.DEPTH(DEPTH)) u_flow (
        .occ      (occ),
        .wr_valid (wr_valid),
        .rd_take  (rd_take),
        .give     (give),
        .fill     (fill),
        .wr_ready (wr_ready)
    );

    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_loc
        word_t src;
        if (i == 0) begin : g_top
            assign src = wr_data;
        end else begin : g_mid
            assign src = loc_data[i-1];
        end

        ftstk_cell #(.WIDTH(WIDTH)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .fill    (fill[i]),
            .give    (give[i]),
            .up_data (src),
            .occ     (occ[i]),
            .data    (loc_data[i])
        );
    end

    assign rd_valid = occ[LAST];
    assign rd_data  = loc_data[LAST];

    logic acc;
    logic tk;
    assign acc = wr_valid && wr_ready;
    assign tk  = rd_valid && rd_take;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (occ == '0));  // R1

    AST_REFUSED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready && !rd_take) |=> ($countones(occ) == $countones($past(occ))));  // R2

    AST_COUNT_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(occ) ==
            $countones($past(occ)) + int'($past(acc)) - int'($past(tk))));  // R8

    AST_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_take) |=> (rd_valid && $stable(rd_data)));  // R6

    AST_PAUSE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!occ[LAST] && !occ[LAST-1]) |=> !rd_valid);  // R4

endmodule

// File: tb/ftstk_top_test.sv
`timescale 1ns/1ps
module ftstk_top_test;

    localparam int D = 14;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_valid;
    logic [W-1:0] wr_data;
    logic         wr_ready;
    logic         rd_valid;
    logic [W-1:0] rd_data;
    logic         rd_take;

    always #2.5 clk = ~clk;

    ftstk_top #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_take(rd_take)
    );

    int checks = 0;
    int errors = 0;
    int wseq   = 0;

    // Reference model: each stored word has a position (0 = top).
    int mpos[$];
    int mdat[$];
    int bottom_data = 0;
    bit bd_known    = 0;
    int sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_ready();
        return (mpos.size() == 0) || (mpos[mpos.size()-1] != 0);
    endfunction

    function automatic bit m_valid();
        return (mpos.size() != 0) && (mpos[0] == D-1);
    endfunction

    task automatic model_step(input bit r, input bit wv, input int wd, input bit tk);
        bit ready;
        bit drop;
        int lim;
        if (r) begin
            mpos.delete();
            mdat.delete();
            return;
        end
        ready = m_ready();
        drop  = 0;
        lim   = D;
        foreach (mpos[i]) begin
            if (mpos[i] == D-1) begin
                if (tk) begin
                    drop = 1;
                    lim  = D;
                end else begin
                    lim = D-1;
                end
            end else begin
                if (mpos[i] + 1 < lim) begin
                    mpos[i]++;
                    if (mpos[i] == D-1) begin
                        bottom_data = mdat[i];
                        bd_known    = 1;
                    end
                end
                lim = mpos[i];
            end
        end
        if (drop) begin
            void'(mpos.pop_front());
            void'(mdat.pop_front());
        end
        if (ready && wv) begin
            mpos.push_back(0);
            mdat.push_back(wd);
        end
    endtask

    task automatic compare();
        chk(rd_valid == m_valid(), "R6", "rd_valid", int'(rd_valid), int'(m_valid()));
        chk(wr_ready == m_ready(), "R2", "wr_ready", int'(wr_ready), int'(m_ready()));
        if (bd_known)
            chk(int'(rd_data) == bottom_data, "R4", "rd_data", int'(rd_data), bottom_data);
    endtask

    // Drive one cycle at the falling edge, step the model, check after the edge.
    task automatic tick(input bit r, input bit wv, input bit tk);
        int wd;
        bit acc;
        wd       = wseq & 15;
        rst      = r;
        wr_valid = wv;
        rd_take  = tk;
        wr_data  = wd[W-1:0];
        acc      = wv && m_ready() && !r;
        if (!r && tk && rd_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R8", "take with empty scoreboard", int'(rd_data), -1);
            end else begin
                chk(int'(rd_data) == sb[0], "R8", "order", int'(rd_data), sb[0]);
                void'(sb.pop_front());
            end
        end
        if (r) sb.delete();
        if (acc) begin
            sb.push_back(wd);
            wseq++;
        end
        model_step(r, wv, wd, tk);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int cnt;
        int d;
        int wps[4] = '{50, 90, 20, 100};
        int tps[4] = '{50, 20, 90, 100};
        rst = 1; wr_valid = 0; rd_take = 0; wr_data = '0;
        @(negedge clk);
        tick(1, 0, 0);
        tick(1, 1, 1);
        // R1: reset state
        chk(rd_valid == 0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        chk(wr_ready == 1, "R1", "wr_ready after reset", int'(wr_ready), 1);

        // R3: lone word latency
        d = wseq & 15;
        tick(0, 1, 0);
        n = 0;
        while (!rd_valid && n < 40) begin
            tick(0, 0, 0);
            n++;
        end
        chk(n == D-1, "R3", "fall-through edges", n, D-1);
        chk(int'(rd_data) == d, "R3", "arrived word", int'(rd_data), d);
        tick(0, 0, 1);

        // R7: take while empty has no effect
        d = int'(rd_data);
        for (int k = 0; k < 5; k++) begin
            tick(0, 0, 1);
            chk(rd_valid == 0, "R7", "rd_valid on idle take", int'(rd_valid), 0);
            chk(wr_ready == 1, "R7", "wr_ready on idle take", int'(wr_ready), 1);
            chk(int'(rd_data) == d, "R7", "rd_data on idle take", int'(rd_data), d);
        end

        // R10: capacity
        cnt = 0;
        for (int k = 0; k < 80; k++) begin
            if (wr_ready) cnt++;
            tick(0, 1, 0);
        end
        chk(cnt == D, "R10", "words accepted", cnt, D);
        chk(wr_ready == 0, "R10", "wr_ready when full", int'(wr_ready), 0);

        // R5: packed column drains continuously
        cnt = 0;
        for (int k = 0; k < D; k++) begin
            if (rd_valid) cnt++;
            tick(0, 0, 1);
        end
        chk(cnt == D, "R5", "valid cycles in drain", cnt, D);
        chk(rd_valid == 0, "R5", "empty after drain", int'(rd_valid), 0);

        // R8: random write and take timing
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 3000; k++) begin
                tick(0, ($urandom_range(99) < wps[p]), ($urandom_range(99) < tps[p]));
            end
        end
        for (int k = 0; k < 60; k++) tick(0, 0, 1);
        chk(sb.size() == 0, "R8", "words left undelivered", sb.size(), 0);

        // R9: reset keeps data, clears occupancy
        n = 0;
        while (!rd_valid && n < 60) begin
            tick(0, 1, 0);
            n++;
        end
        tick(0, 1, 0);
        d = int'(rd_data);
        tick(1, 0, 0);
        chk(rd_valid == 0, "R9", "rd_valid after mid reset", int'(rd_valid), 0);
        chk(wr_ready == 1, "R9", "wr_ready after mid reset", int'(wr_ready), 1);
        chk(int'(rd_data) == d, "R9", "rd_data kept", int'(rd_data), d);
        for (int k = 0; k < 200; k++) begin
            tick(0, ($urandom_range(99) < 60), ($urandom_range(99) < 60));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule